// File: doc/BRIEF.md
# Broadcast ECC Initialization Sequencer

This block sits in front of a backplane of card slots. Each slot has its own select line, and all slots share one word address bus. After reset it runs a clearing pass. Every slot select is driven high together, and a single ascending sweep writes an all-zero word with freshly encoded check bits into every location. One pass therefore leaves every installed card holding valid check bits.

Once the pass is finished, the block accepts host requests on a valid/ready stream. It decodes the upper host address bits into exactly one slot select, and returns read data on a second valid/ready stream. A small register port gives software three controls: switching read checking off, seeing and clearing a sticky error flag, and seeing whether the clearing pass is complete.

Back-pressure rules:
- A request transfers on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` stays low while the sweep runs and while an access or response is outstanding.
- A response holds `rsp_valid` and its payload unchanged until `rsp_ready` is seen high.
- Writes produce no response.

Top module: `ecc_bcast_init`

## Requirements
- R1: While reset (`rst_n` low, synchronous) is held, `csr_rdata` reads 0x01 (checking on, no error, not cleared), and `req_ready`, `rsp_valid`, `mem_we` and `mem_re` are all low.
- R2: After reset the sweep runs once. It holds every bit of `mem_sel` high and pulses `mem_we` on consecutive cycles, with `mem_addr` stepping from 0 up to 2^ADDR_W-1, each address once.
- R3: Every sweep write carries all-zero data and all-zero check bits. The check code uses even parity, so the all-zero word encodes to zero. After the sweep, every location of every slot holds zero.
- R4: Register bit 2 (cleared-flag, read-only) rises in the cycle after the last sweep write and then stays high. `req_ready` stays low until it rises.
- R5: A host write drives `mem_we` for one cycle. During that cycle `mem_sel` has only bit `req_addr[ADDR_W+SEL_W-1:ADDR_W]` high, and `mem_addr` equals `req_addr[ADDR_W-1:0]`. Only that slot's location changes.
- R6: A host read pulses `mem_re` in the cycle after acceptance. The card returns data one cycle later. The response carries the word stored at that slot and address.
- R7: With register bit 0 (check enable) set, a read whose stored data or check bits differ from the encoding by one bit returns `rsp_err`=1 and sets register bit 1 (sticky error).
- R8: Writing 1 to register bit 1 clears it; writing 0 to it leaves it unchanged.
- R9: With register bit 0 cleared, a check mismatch is ignored: `rsp_err` is 0 and register bit 1 is unchanged.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response and its payload stay unchanged and `req_ready` stays low.
- R11: If a checked read sets the error flag on the same edge that software writes 1 to clear it, the flag ends up set.
- R12: Writes to register bit 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | SEL_W+ADDR_W | Slot index (upper bits) and word address (lower bits) |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_rdata | output | DATA_W | Read data |
| rsp_err | output | 1 | Check mismatch on this read (only when checking is on) |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | CSR_W | Register write data |
| csr_rdata | output | CSR_W | Register readback: bit0 check enable, bit1 error, bit2 cleared |
| mem_sel | output | SLOTS | Per-slot select |
| mem_addr | output | ADDR_W | Shared word address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | DATA_W | Write data to cards |
| mem_wchk | output | CHK_W | Check bits to cards |
| mem_rdata | input | DATA_W | Read data from cards, valid the cycle after `mem_re` |
| mem_rchk | input | CHK_W | Stored check bits from cards, same timing |

## Verification
Two events can land on the same clock edge and both act on the sticky error flag. One is the hardware capture of a checked read mismatch. The other is a software write-one-to-clear on the register port. The bench corrupts a stored word in its card model, then issues a read. It raises the clear strobe exactly in the cycle when the card data returns, which is two cycles after acceptance. It then requires the flag to still read 1 and the response to carry the error.

// File: rtl/eccinit_pkg.sv
package eccinit_pkg;
  typedef enum logic [1:0] {
    HP_IDLE  = 2'd0,
    HP_ISSUE = 2'd1,
    HP_WAIT  = 2'd2,
    HP_RESP  = 2'd3
  } hp_state_e;

  typedef enum logic [1:0] {
    SW_START = 2'd0,
    SW_RUN   = 2'd1,
    SW_DONE  = 2'd2
  } sweep_state_e;

  localparam int CSR_BIT_CHK_EN = 0;
  localparam int CSR_BIT_ERR    = 1;
  localparam int CSR_BIT_DONE   = 2;
endpackage

// File: rtl/eccinit_chk_gen.sv
// Even-parity check-bit encoder: each low check bit covers the data bits
// whose (index+1) has that bit set; the top check bit covers all data bits.
module eccinit_chk_gen #(
  parameter int DATA_W = 16,
  parameter int CHK_W  = 6
) (
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);
  for (genvar i = 0; i < CHK_W - 1; i++) begin : g_bit
    logic [DATA_W-1:0] mask;
    for (genvar j = 0; j < DATA_W; j++) begin : g_m
      assign mask[j] = (((j + 1) >> i) % 2) == 1;
    end
    assign chk[i] = ^(data & mask);
  end
  assign chk[CHK_W-1] = ^data;
endmodule

// File: rtl/eccinit_sweep.sv
module eccinit_sweep #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              sweep_active,
  output logic [ADDR_W-1:0] sweep_addr,
  output logic              sweep_done
);
  import eccinit_pkg::*;

  sweep_state_e state_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SW_START;
      addr_q  <= '0;
    end else begin
      case (state_q)
        SW_START: state_q <= SW_RUN;
        SW_RUN: begin
          if (addr_q == '1) state_q <= SW_DONE;
          else addr_q <= addr_q + 1'b1;
        end
        default: state_q <= SW_DONE;
      endcase
    end
  end

  assign sweep_active = (state_q == SW_RUN);
  assign sweep_done   = (state_q == SW_DONE);
  assign sweep_addr   = addr_q;
endmodule

// File: rtl/eccinit_csr.sv
module eccinit_csr #(
  parameter int CSR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic [CSR_W-1:0] csr_wdata,
  input  logic             err_set,
  input  logic             init_done,
  output logic [CSR_W-1:0] csr_rdata,
  output logic             chk_en
);
  import eccinit_pkg::*;

  logic chk_en_q;
  logic err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_en_q <= 1'b1;
      err_q    <= 1'b0;
    end else begin
      if (csr_we) chk_en_q <= csr_wdata[CSR_BIT_CHK_EN];
      // hardware set has priority over software clear
      if (err_set) err_q <= 1'b1;
      else if (csr_we && csr_wdata[CSR_BIT_ERR]) err_q <= 1'b0;
    end
  end

  always_comb begin
    csr_rdata                 = '0;
    csr_rdata[CSR_BIT_CHK_EN] = chk_en_q;
    csr_rdata[CSR_BIT_ERR]    = err_q;
    csr_rdata[CSR_BIT_DONE]   = init_done;
  end

  assign chk_en = chk_en_q;
endmodule

// File: rtl/eccinit_host_path.sv
module eccinit_host_path #(
  parameter int SLOTS  = 16,
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int CHK_W  = 6,
  parameter int SEL_W  = 4,
  localparam int HA_W  = SEL_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic              chk_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [HA_W-1:0]   req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic [SLOTS-1:0]  host_sel,
  output logic [ADDR_W-1:0] host_addr,
  output logic              host_we,
  output logic              host_re,
  output logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [CHK_W-1:0]  mem_rchk,
  output logic              err_set
);
  import eccinit_pkg::*;

  hp_state_e         state_q;
  logic              wr_q;
  logic [SEL_W-1:0]  slot_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              rsp_err_q;
  logic [CHK_W-1:0]  calc_chk;
  logic              mismatch;

  eccinit_chk_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_rd_chk (
    .data (mem_rdata),
    .chk  (calc_chk)
  );

  assign mismatch  = chk_en && (|(calc_chk ^ mem_rchk));
  assign req_ready = init_done && (state_q == HP_IDLE);
  assign err_set   = (state_q == HP_WAIT) && mismatch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= HP_IDLE;
      wr_q       <= 1'b0;
      slot_q     <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      rsp_data_q <= '0;
      rsp_err_q  <= 1'b0;
    end else begin
      case (state_q)
        HP_IDLE: begin
          if (req_valid && req_ready) begin
            wr_q    <= req_write;
            slot_q  <= req_addr[HA_W-1:ADDR_W];
            addr_q  <= req_addr[ADDR_W-1:0];
            wdata_q <= req_wdata;
            state_q <= HP_ISSUE;
          end
        end
        HP_ISSUE: state_q <= wr_q ? HP_IDLE : HP_WAIT;
        HP_WAIT: begin
          rsp_data_q <= mem_rdata;
          rsp_err_q  <= mismatch;
          state_q    <= HP_RESP;
        end
        default: begin
          if (rsp_ready) state_q <= HP_IDLE;
        end
      endcase
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_dec
    assign host_sel[s] = (state_q == HP_ISSUE) && (slot_q == SEL_W'(s));
  end

  assign host_addr  = addr_q;
  assign host_we    = (state_q == HP_ISSUE) && wr_q;
  assign host_re    = (state_q == HP_ISSUE) && !wr_q;
  assign host_wdata = wdata_q;
  assign rsp_valid  = (state_q == HP_RESP);
  assign rsp_rdata  = rsp_data_q;
  assign rsp_err    = rsp_err_q;
endmodule

// File: rtl/ecc_bcast_init.sv
module ecc_bcast_init #(
  parameter int SLOTS  = 16,
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int CSR_W  = 8,
  localparam int SEL_W = $clog2(SLOTS),
  localparam int HA_W  = SEL_W + ADDR_W,
  localparam int CHK_W = $clog2(DATA_W + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [HA_W-1:0]   req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  input  logic              csr_we,
  input  logic [CSR_W-1:0]  csr_wdata,
  output logic [CSR_W-1:0]  csr_rdata,
  output logic [SLOTS-1:0]  mem_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [CHK_W-1:0]  mem_wchk,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [CHK_W-1:0]  mem_rchk
);
  logic              sweep_active;
  logic [ADDR_W-1:0] sweep_addr;
  logic              sweep_done;
  logic              chk_en;
  logic              err_set;
  logic [SLOTS-1:0]  host_sel;
  logic [ADDR_W-1:0] host_addr;
  logic              host_we;
  logic              host_re;
  logic [DATA_W-1:0] host_wdata;

  eccinit_sweep #(.ADDR_W(ADDR_W)) u_sweep (
    .clk          (clk),
    .rst_n        (rst_n),
    .sweep_active (sweep_active),
    .sweep_addr   (sweep_addr),
    .sweep_done   (sweep_done)
  );

  eccinit_csr #(.CSR_W(CSR_W)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_we    (csr_we),
    .csr_wdata (csr_wdata),
    .err_set   (err_set),
    .init_done (sweep_done),
    .csr_rdata (csr_rdata),
    .chk_en    (chk_en)
  );

  eccinit_host_path #(
    .SLOTS(SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHK_W(CHK_W), .SEL_W(SEL_W)
  ) u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_done  (sweep_done),
    .chk_en     (chk_en),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err),
    .host_sel   (host_sel),
    .host_addr  (host_addr),
    .host_we    (host_we),
    .host_re    (host_re),
    .host_wdata (host_wdata),
    .mem_rdata  (mem_rdata),
    .mem_rchk   (mem_rchk),
    .err_set    (err_set)
  );

  // Backplane mux: the sweep owns the bus until it completes.
  assign mem_sel   = sweep_active ? {SLOTS{1'b1}} : host_sel;
  assign mem_addr  = sweep_active ? sweep_addr : host_addr;
  assign mem_we    = sweep_active || host_we;
  assign mem_re    = host_re;
  assign mem_wdata = sweep_active ? '0 : host_wdata;

  // One encoder serves both sweep and host writes.
  eccinit_chk_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_wr_chk (
    .data (mem_wdata),
    .chk  (mem_wchk)
  );
endmodule

// File: rtl/ecc_bcast_init_chk.sv
module ecc_bcast_init_chk #(
  parameter int SLOTS  = 16,
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int CSR_W  = 8,
  parameter int CHK_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic [CSR_W-1:0]  csr_rdata,
  input logic [SLOTS-1:0]  mem_sel,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [CHK_W-1:0]  mem_wchk
);
  logic done;
  assign done = csr_rdata[2];

  a_r2_sweep_all_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !done) |-> (&mem_sel));

  a_r2_sweep_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !done && $past(mem_we && !done)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  a_r3_sweep_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !done) |-> (mem_wdata == '0 && mem_wchk == '0));

  a_r4_no_ready_early: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !req_ready);

  a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r5_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (mem_we || mem_re)) |-> ($countones(mem_sel) == 1));

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  a_r10_no_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

bind ecc_bcast_init ecc_bcast_init_chk #(
  .SLOTS(SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CSR_W(CSR_W), .CHK_W(CHK_W)
) u_chk (.*);

// File: tb/ecc_bcast_init_tb.sv
`timescale 1ns/1ps
module ecc_bcast_init_tb;
  localparam int SLOTS  = 16;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int CSR_W  = 8;
  localparam int SEL_W  = 4;
  localparam int HA_W   = SEL_W + ADDR_W;
  localparam int CHK_W  = 6;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [HA_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic rsp_valid, rsp_ready = 1'b1, rsp_err;
  logic [DATA_W-1:0] rsp_rdata;
  logic csr_we = 1'b0;
  logic [CSR_W-1:0] csr_wdata = '0, csr_rdata;
  logic [SLOTS-1:0] mem_sel;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_we, mem_re;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic [CHK_W-1:0] mem_wchk, mem_rchk;

  always #2.5 clk = ~clk;

  ecc_bcast_init #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CSR_W(CSR_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_wchk(mem_wchk), .mem_rdata(mem_rdata), .mem_rchk(mem_rchk)
  );

  // Card model: word = {check, data}, read data registered one cycle
  logic [CHK_W+DATA_W-1:0] cards [SLOTS][DEPTH];
  logic [CHK_W+DATA_W-1:0] rd_q = '0;
  assign mem_rdata = rd_q[DATA_W-1:0];
  assign mem_rchk  = rd_q[CHK_W+DATA_W-1:DATA_W];

  always @(posedge clk) begin
    for (int s = 0; s < SLOTS; s++) begin
      if (mem_we && mem_sel[s]) cards[s][mem_addr] <= {mem_wchk, mem_wdata};
      if (mem_re && mem_sel[s]) rd_q <= cards[s][mem_addr];
    end
  end

  int n_checks = 0;
  int n_fail = 0;
  logic [DATA_W:0] exp_q[$];
  string tag_q[$];

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Sweep monitor (R2, R3)
  int sweep_cnt = 0, sweep_bad = 0, sweep_nonzero = 0;
  always @(negedge clk) begin
    if (rst_n && mem_we && !csr_rdata[2]) begin
      if (mem_sel !== {SLOTS{1'b1}} || mem_addr !== ADDR_W'(sweep_cnt)) sweep_bad++;
      if (mem_wdata !== '0 || mem_wchk !== '0) sweep_nonzero++;
      sweep_cnt++;
    end
  end

  // Response monitor: scoreboard pop
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check("R6", "unexpected response", 32'(rsp_rdata), 32'hFFFF_FFFF);
      end else begin
        logic [DATA_W:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, "rsp data", 32'(rsp_rdata), 32'(e[DATA_W-1:0]));
        check(t, "rsp err", 32'(rsp_err), 32'(e[DATA_W]));
      end
    end
  end

  task automatic wait_ready();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic host_write(input logic [HA_W-1:0] a, input logic [DATA_W-1:0] d);
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic host_read(input logic [HA_W-1:0] a, input logic [DATA_W-1:0] d,
                           input logic e, input string t);
    wait_ready();
    exp_q.push_back({e, d}); tag_q.push_back(t);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic csr_write(input logic [CSR_W-1:0] v);
    @(negedge clk);
    csr_we = 1'b1; csr_wdata = v;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int s = 0; s < SLOTS; s++)
      for (int a = 0; a < DEPTH; a++)
        cards[s][a] = 22'h2A5A5 ^ 22'(s * 37 + a);

    repeat (3) @(negedge clk);
    check("R1", "csr reset", 32'(csr_rdata), 32'h01);
    check("R1", "ready/valid/strobes in reset",
          {28'd0, req_ready, rsp_valid, mem_we, mem_re}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4", "ready low during sweep", 32'(req_ready), 32'h0);
    while (!csr_rdata[2]) @(negedge clk);
    check("R2", "sweep write count", 32'(sweep_cnt), 32'(DEPTH));
    check("R2", "sweep select/order errors", 32'(sweep_bad), 32'h0);
    check("R3", "sweep nonzero writes", 32'(sweep_nonzero), 32'h0);
    begin
      int nz = 0;
      for (int s = 0; s < SLOTS; s++)
        for (int a = 0; a < DEPTH; a++)
          if (cards[s][a] !== '0) nz++;
      check("R3", "cleared locations nonzero", 32'(nz), 32'h0);
    end
    check("R4", "ready after sweep", 32'(req_ready), 32'h1);

    host_write(8'h53, 16'hBEEF);
    @(negedge clk);
    check("R5", "slot5 addr3 data", 32'(cards[5][3][DATA_W-1:0]), 32'hBEEF);
    check("R5", "slot4 untouched", 32'(cards[4][3]), 32'h0);
    check("R5", "slot6 untouched", 32'(cards[6][3]), 32'h0);
    host_write(8'h00, 16'h1234);
    host_write(8'hFF, 16'h8001);
    host_read(8'h53, 16'hBEEF, 1'b0, "R6");
    host_read(8'h00, 16'h1234, 1'b0, "R6");
    host_read(8'hFF, 16'h8001, 1'b0, "R6");
    host_read(8'h2A, 16'h0000, 1'b0, "R6");
    drain();

    cards[5][3][4] = ~cards[5][3][4];
    host_read(8'h53, 16'hBEFF, 1'b1, "R7");
    drain();
    check("R7", "error flag set", 32'(csr_rdata[1]), 32'h1);
    csr_write(8'h01);
    check("R8", "write 0 keeps error", 32'(csr_rdata[1]), 32'h1);
    csr_write(8'h03);
    check("R8", "write 1 clears error", 32'(csr_rdata[1]), 32'h0);

    csr_write(8'h01);
    check("R12", "done unaffected by 0", 32'(csr_rdata), 32'h05);
    csr_write(8'h04);
    check("R12", "done unaffected by 1, check off", 32'(csr_rdata), 32'h04);
    host_read(8'h53, 16'hBEFF, 1'b0, "R9");
    drain();
    check("R9", "error flag stays clear", 32'(csr_rdata[1]), 32'h0);
    csr_write(8'h01);

    rsp_ready = 1'b0;
    host_read(8'h00, 16'h1234, 1'b0, "R10");
    repeat (6) @(negedge clk);
    check("R10", "valid held", 32'(rsp_valid), 32'h1);
    check("R10", "data held", 32'(rsp_rdata), 32'h1234);
    check("R10", "no accept while pending", 32'(req_ready), 32'h0);
    rsp_ready = 1'b1;
    drain();

    // R11: clear strobe lands on the edge where the mismatch is captured
    wait_ready();
    exp_q.push_back({1'b1, 16'hBEFF}); tag_q.push_back("R11");
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h53;
    @(negedge clk);
    req_valid = 1'b0;
    check("R6", "read strobe after accept", 32'(mem_re), 32'h1);
    @(negedge clk);
    csr_we = 1'b1; csr_wdata = 8'h03;
    @(negedge clk);
    csr_we = 1'b0;
    check("R11", "set wins over clear", 32'(csr_rdata[1]), 32'h1);
    drain();

    finish_run();
  end
endmodule